// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block keeps the modem control byte of a 16550-class UART and turns it into pin and mode signals. Host writes set the two active-low handshake outputs (data-terminal-ready and request-to-send), the enable of the interrupt pin driver, a local loopback mode, and three extended controls. The extended controls are: an any-character-resumes-transmit flag, an infrared path select, and a divide-by-four prescaler for the baud generator. A register 1 pulls the matching handshake pin low.

In loopback the block cuts the external serial and handshake pins off. The transmit pin idles high and both handshake pins sit inactive high. The serial transmit stream is fed back to the receiver input. The internal modem-status lines are driven from the control byte instead of the pins: request-to-send feeds clear-to-send, terminal-ready feeds set-ready, bit 2 feeds ring-indicate and bit 3 feeds carrier-detect. The extended bits 5 to 7 only change when an enhanced-mode input is high. While that input is low they read as 0 and have no effect. The prescaler does not make a new clock. It makes a one-cycle baud enable pulse.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, rd_data is 0x00, dtr_n_pin and rts_n_pin are 1, irq_oe is 0, tx_pin is 1, and all four internal modem lines are 1.
- R2: Outside loopback, bit 0 = 1 drives dtr_n_pin to 0 and bit 0 = 0 drives it to 1.
- R3: Outside loopback, bit 1 = 1 drives rts_n_pin to 0 and bit 1 = 0 drives it to 1.
- R4: irq_oe equals bit 3 (1 = interrupt pin driven, 0 = high impedance), both in loopback and outside it.
- R5: rd_data returns bits 4:0 as last written. Bits 7:5 are returned as last written while enh_en is 1.
- R6: While enh_en is 0, a write leaves the stored bits 7:5 unchanged. Those bits then read as 0, and xon_any_en, irda_en and the prescaler act as if they were 0. When enh_en returns to 1, the earlier stored values come back.
- R7: With bit 4 = 1 (loopback), tx_pin, dtr_n_pin and rts_n_pin are 1, rx_ser_out follows tx_ser_in, and rx_pin has no effect.
- R8: In loopback the internal lines take these values: cts_n_int = NOT bit 1, dsr_n_int = NOT bit 0, ri_n_int = NOT bit 2, dcd_n_int = NOT bit 3.
- R9: Outside loopback, tx_pin follows tx_ser_in, rx_ser_out follows rx_pin, and each internal modem line follows its matching pin input.
- R10: With effective bit 7 = 0, baud_tick is 1 on every cycle. With effective bit 7 = 1, baud_tick is 1 on exactly one cycle in four and is never high on two cycles in a row.
- R11: xon_any_en equals effective bit 5 and irda_en equals effective bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| enh_en | input | 1 | Enhanced-mode enable for bits 7:5 |
| rd_data | output | 8 | Effective control byte readback |
| dtr_n_pin | output | 1 | Terminal-ready pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| irq_oe | output | 1 | Interrupt pin driver enable |
| xon_any_en | output | 1 | Any-character-resumes-transmit enable |
| irda_en | output | 1 | Infrared path select |
| baud_tick | output | 1 | Prescaled baud generator enable |
| tx_ser_in | input | 1 | Serial data from the transmitter |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rx_ser_out | output | 1 | Serial data to the receiver |
| cts_n_pin | input | 1 | Clear-to-send pin |
| dsr_n_pin | input | 1 | Set-ready pin |
| ri_n_pin | input | 1 | Ring-indicate pin |
| dcd_n_pin | input | 1 | Carrier-detect pin |
| cts_n_int | output | 1 | Internal clear-to-send |
| dsr_n_int | output | 1 | Internal set-ready |
| ri_n_int | output | 1 | Internal ring-indicate |
| dcd_n_int | output | 1 | Internal carrier-detect |

## Verification
A control byte is captured at one rising edge and stored. Every result that depends on it (readback, handshake pins, driver enable, extended flags, loopback routing and tick mode) is registered again, so these results show up after the second rising edge. A change of enh_en alone shows up after the next edge. Serial and modem-line paths go through one register, so each pin value shows up one edge after it is sampled. The bench drives inputs on falling edges. It samples control results two falling edges after a write and pass-through results one falling edge after their input changes, and it counts baud ticks over a 40-cycle window once the mode has settled.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int CTL_W   = 8;
  localparam int LOCK_LO = 5;
  localparam int N_LINES = 4;
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  typedef struct packed {
    logic pre_div4;
    logic irda;
    logic xon_any;
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } mctl_t;
endpackage

// File: rtl/mctl_reg.sv
module mctl_reg #(
  parameter int W      = 8,
  parameter int LOCK_L = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         enh_en,
  output logic [W-1:0] ctl_eff
);
  logic [W-1:0] raw_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= LOCK_L) begin : g_locked
      always_ff @(posedge clk) begin
        if (rst) raw_q[i] <= 1'b0;
        else if (wr_en && enh_en) raw_q[i] <= wr_data[i];
      end
      assign ctl_eff[i] = raw_q[i] & enh_en;
    end else begin : g_open
      always_ff @(posedge clk) begin
        if (rst) raw_q[i] <= 1'b0;
        else if (wr_en) raw_q[i] <= wr_data[i];
      end
      assign ctl_eff[i] = raw_q[i];
    end
  end

  assert_locked_bits_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enh_en) |=> (raw_q[W-1:LOCK_L] == $past(raw_q[W-1:LOCK_L])));
endmodule

// File: rtl/mctl_prescale.sv
module mctl_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;
  logic          started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tick_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick_q    <= div_sel ? (cnt_q == LAST) : 1'b1;
      started_q <= 1'b1;
    end
  end

  assign tick = tick_q;

  assert_div1_every_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (started_q && !$past(div_sel)) |-> tick_q);

  assert_div4_no_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
    (tick_q && $past(div_sel) && $past(div_sel, 2)) |-> !$past(tick_q));
endmodule

// File: rtl/mctl_loop_mux.sv
module mctl_loop_mux #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loop,
  input  logic         tx_ser_in,
  input  logic         rx_pin,
  input  logic [N-1:0] ext_n,
  input  logic [N-1:0] lb_n,
  output logic         tx_pin,
  output logic         rx_ser_out,
  output logic [N-1:0] int_n
);
  logic         tx_q, rx_q;
  logic [N-1:0] int_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      tx_q <= loop ? 1'b1 : tx_ser_in;
      rx_q <= loop ? tx_ser_in : rx_pin;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) int_q[i] <= 1'b1;
      else     int_q[i] <= loop ? lb_n[i] : ext_n[i];
    end
  end

  assign tx_pin     = tx_q;
  assign rx_ser_out = rx_q;
  assign int_n      = int_q;

  assert_loop_tx_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $past(loop) |-> tx_pin);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import modem_ctl_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             enh_en,
  output logic [CTL_W-1:0] rd_data,
  output logic             dtr_n_pin,
  output logic             rts_n_pin,
  output logic             irq_oe,
  output logic             xon_any_en,
  output logic             irda_en,
  output logic             baud_tick,
  input  logic             tx_ser_in,
  output logic             tx_pin,
  input  logic             rx_pin,
  output logic             rx_ser_out,
  input  logic             cts_n_pin,
  input  logic             dsr_n_pin,
  input  logic             ri_n_pin,
  input  logic             dcd_n_pin,
  output logic             cts_n_int,
  output logic             dsr_n_int,
  output logic             ri_n_int,
  output logic             dcd_n_int
);
  logic [CTL_W-1:0]   ctl_eff;
  mctl_t              c;
  logic [N_LINES-1:0] ext_n, lb_n, int_n;
  logic [CTL_W-1:0]   rd_q;
  logic dtr_q, rts_q, oe_q, xon_q, irda_q;

  mctl_reg #(.W(CTL_W), .LOCK_L(LOCK_LO)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .enh_en(enh_en), .ctl_eff(ctl_eff)
  );

  assign c = mctl_t'(ctl_eff);

  always_comb begin
    ext_n        = '1;
    ext_n[L_CTS] = cts_n_pin;
    ext_n[L_DSR] = dsr_n_pin;
    ext_n[L_RI]  = ri_n_pin;
    ext_n[L_DCD] = dcd_n_pin;
    lb_n         = '1;
    lb_n[L_CTS]  = ~c.rts;
    lb_n[L_DSR]  = ~c.dtr;
    lb_n[L_RI]   = ~c.op1;
    lb_n[L_DCD]  = ~c.op2;
  end

  mctl_loop_mux #(.N(N_LINES)) u_mux (
    .clk(clk), .rst(rst), .loop(c.loop), .tx_ser_in(tx_ser_in),
    .rx_pin(rx_pin), .ext_n(ext_n), .lb_n(lb_n),
    .tx_pin(tx_pin), .rx_ser_out(rx_ser_out), .int_n(int_n)
  );

  mctl_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .div_sel(c.pre_div4), .tick(baud_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      dtr_q  <= 1'b1;
      rts_q  <= 1'b1;
      oe_q   <= 1'b0;
      xon_q  <= 1'b0;
      irda_q <= 1'b0;
    end else begin
      rd_q   <= ctl_eff;
      dtr_q  <= c.loop | ~c.dtr;
      rts_q  <= c.loop | ~c.rts;
      oe_q   <= c.op2;
      xon_q  <= c.xon_any;
      irda_q <= c.irda;
    end
  end

  assign rd_data    = rd_q;
  assign dtr_n_pin  = dtr_q;
  assign rts_n_pin  = rts_q;
  assign irq_oe     = oe_q;
  assign xon_any_en = xon_q;
  assign irda_en    = irda_q;
  assign cts_n_int  = int_n[L_CTS];
  assign dsr_n_int  = int_n[L_DSR];
  assign ri_n_int   = int_n[L_RI];
  assign dcd_n_int  = int_n[L_DCD];

  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dtr_n_pin && rts_n_pin && !irq_oe && rd_data == '0));

  assert_loop_pins_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $past(c.loop) |-> (dtr_n_pin && rts_n_pin));

  assert_dtr_low_when_set_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!c.loop && c.dtr) |-> !dtr_n_pin);

  assert_rts_low_when_set_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!c.loop && c.rts) |-> !rts_n_pin);
endmodule

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic enh_en = 1'b0;
  logic [7:0] rd_data;
  logic dtr_n_pin, rts_n_pin, irq_oe, xon_any_en, irda_en, baud_tick;
  logic tx_ser_in = 1'b1;
  logic tx_pin;
  logic rx_pin = 1'b1;
  logic rx_ser_out;
  logic cts_n_pin = 1'b1, dsr_n_pin = 1'b1, ri_n_pin = 1'b1, dcd_n_pin = 1'b1;
  logic cts_n_int, dsr_n_int, ri_n_int, dcd_n_int;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_raw = 8'h00;

  always #4 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .enh_en(enh_en),
    .rd_data(rd_data), .dtr_n_pin(dtr_n_pin), .rts_n_pin(rts_n_pin),
    .irq_oe(irq_oe), .xon_any_en(xon_any_en), .irda_en(irda_en),
    .baud_tick(baud_tick), .tx_ser_in(tx_ser_in), .tx_pin(tx_pin),
    .rx_pin(rx_pin), .rx_ser_out(rx_ser_out), .cts_n_pin(cts_n_pin),
    .dsr_n_pin(dsr_n_pin), .ri_n_pin(ri_n_pin), .dcd_n_pin(dcd_n_pin),
    .cts_n_int(cts_n_int), .dsr_n_int(dsr_n_int), .ri_n_int(ri_n_int),
    .dcd_n_int(dcd_n_int)
  );

  function automatic logic [7:0] eff_of(logic [7:0] raw, logic enh);
    return enh ? raw : {3'b000, raw[4:0]};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [7:0] d, logic e);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; enh_en = e;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    m_raw[4:0] = d[4:0];
    if (e) m_raw[7:5] = d[7:5];
  endtask

  task automatic check_ctl();
    logic [7:0] e;
    e = eff_of(m_raw, enh_en);
    chk("R5 readback", rd_data, e);
    chk("R2 dtr_n", {7'd0, dtr_n_pin}, {7'd0, e[4] | ~e[0]});
    chk("R3 rts_n", {7'd0, rts_n_pin}, {7'd0, e[4] | ~e[1]});
    chk("R4 irq_oe", {7'd0, irq_oe}, {7'd0, e[3]});
    chk("R11 xon_any", {7'd0, xon_any_en}, {7'd0, e[5]});
    chk("R11 irda", {7'd0, irda_en}, {7'd0, e[6]});
  endtask

  task automatic check_paths(logic t, logic r, logic [3:0] pins);
    logic [7:0] e;
    e = eff_of(m_raw, enh_en);
    tx_ser_in = t; rx_pin = r;
    cts_n_pin = pins[0]; dsr_n_pin = pins[1]; ri_n_pin = pins[2]; dcd_n_pin = pins[3];
    @(negedge clk);
    if (e[4]) begin
      chk("R7 tx idle", {7'd0, tx_pin}, 8'd1);
      chk("R7 rx loop", {7'd0, rx_ser_out}, {7'd0, t});
      chk("R8 modem lb", {4'd0, dcd_n_int, ri_n_int, dsr_n_int, cts_n_int},
          {4'd0, ~e[3], ~e[2], ~e[0], ~e[1]});
    end else begin
      chk("R9 tx pass", {7'd0, tx_pin}, {7'd0, t});
      chk("R9 rx pass", {7'd0, rx_ser_out}, {7'd0, r});
      chk("R9 modem pass", {4'd0, dcd_n_int, ri_n_int, dsr_n_int, cts_n_int},
          {4'd0, pins});
    end
  endtask

  task automatic check_ticks(logic div4);
    int cnt = 0;
    int pairs = 0;
    logic prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (baud_tick) cnt++;
      if (baud_tick && prev) pairs++;
      prev = baud_tick;
    end
    chk("R10 tick count", 8'(cnt), div4 ? 8'd10 : 8'd40);
    if (div4) chk("R10 no back-to-back", 8'(pairs), 8'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 pins", {4'd0, dtr_n_pin, rts_n_pin, irq_oe, tx_pin}, 8'b0000_1101);
    chk("R1 modem int", {4'd0, dcd_n_int, ri_n_int, dsr_n_int, cts_n_int}, 8'h0F);
    check_ticks(1'b0);

    // directed: handshake bits and interrupt enable
    do_write(8'h01, 1'b0); check_ctl();
    do_write(8'h02, 1'b0); check_ctl();
    do_write(8'h08, 1'b0); check_ctl();
    check_paths(1'b0, 1'b1, 4'b1010);
    check_paths(1'b1, 1'b0, 4'b0101);

    // loopback: pins idle, rx_pin ignored, internal modem from control byte
    do_write(8'h1F, 1'b0); check_ctl();
    check_paths(1'b0, 1'b1, 4'b0000);
    check_paths(1'b1, 1'b0, 4'b1111);
    do_write(8'h15, 1'b0); check_ctl();
    check_paths(1'b0, 1'b0, 4'b0000);

    // R6 lock of extended bits
    do_write(8'hE0, 1'b1); check_ctl();
    check_ticks(1'b1);
    enh_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check_ctl();
    check_ticks(1'b0);
    do_write(8'h03, 1'b0); check_ctl();
    chk("R6 upper masked", {5'd0, rd_data[7:5]}, 8'd0);
    enh_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 stored bits kept", rd_data, 8'hE3);
    check_ctl();
    check_ticks(1'b1);
    do_write(8'h40, 1'b1); check_ctl();
    check_ticks(1'b0);
    do_write(8'hA0, 1'b1); check_ctl();

    // random phase
    for (int k = 0; k < 300; k++) begin
      logic [7:0] d;
      logic e;
      logic [3:0] p;
      d = 8'($urandom);
      e = 1'($urandom);
      p = 4'($urandom);
      do_write(d, e);
      check_ctl();
      check_paths(1'($urandom), 1'($urandom), p);
      if (k % 50 == 0) check_ticks(eff_of(m_raw, enh_en) >> 7 != 0);
    end
    finish_run();
  end
endmodule